// File: doc/BRIEF.md
# Slot-Gated Processor Byte Port

This block is the processor's only way into a display memory that the display controller owns outright. The processor never drives the memory directly. It first sets an internal 14-bit byte pointer. It then posts single-byte read or write requests. Each request waits in a one-entry holding register until the display schedule leaves a memory cycle unused. The access is made in that cycle. The block then pulses a completion flag and steps the pointer, so a run of consecutive bytes needs only one address load.

How often a spare cycle comes up depends on the display mode. In the normal modes only a fraction of cycles are spare. When the display is blanked, every cycle is spare. Loading the pointer with the read option set also fetches the byte at that address straight away. The first byte of a read run is therefore ready in the same way as every byte after it. Read data stays in an output latch until the next read finishes.

Top module: `cpu_slot_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_en`, `rd_data` and `cur_addr` are all zero.
- R2: `addr_load` with `addr_rd`=0, made while not busy, places `addr_in` on `cur_addr` in the next cycle and performs no memory access.
- R3: `addr_load` with `addr_rd`=1, made while not busy, loads the pointer and posts a read of that byte. On completion `rd_data` holds the byte at `addr_in` and `cur_addr` is `addr_in`+1.
- R4: A write request (`req_valid`=1, `req_write`=1) stores `req_wdata` at `cur_addr` in exactly one memory cycle with `mem_we`=1. On completion the pointer advances by one.
- R5: A read request (`req_valid`=1, `req_write`=0) copies the byte at `cur_addr` into `rd_data`. On completion the pointer advances by one.
- R6: A 3-bit slot counter is cleared by reset and increments every cycle. `mem_en` is high only in spare slots:
  - mode 0: counter mod 4 = 3;
  - modes 1 and 3: counter = 7;
  - mode 2 (blanked): every cycle.

  A request made in cycle c completes with `done` no later than cycle c+5 in mode 0 and c+9 in mode 1, and exactly in c+2 in mode 2.
- R7: `done` is a one-cycle pulse in the cycle after the memory access. `busy` is high from the cycle after acceptance through the access cycle, and is low when `done` is high.
- R8: While `busy` is high, `req_valid` and `addr_load` are ignored, so at most one request is outstanding.
- R9: The pointer wraps from 0x3FFF to 0x0000 after an access.
- R10: `rd_data` changes only when a read completes. Write completions leave it unchanged.
- R11: If `addr_load` and `req_valid` arrive in the same cycle, the load is taken and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Slot schedule select (0: 1 in 4, 1 and 3: 1 in 8, 2: all) |
| addr_load | input | 1 | Load pointer strobe |
| addr_rd | input | 1 | With `addr_load`: prefetch the addressed byte |
| addr_in | input | 14 | Pointer value to load |
| req_valid | input | 1 | Post one byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | An access is outstanding |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Latched byte from the last completed read |
| cur_addr | output | 14 | Current pointer |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 14 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the cycle `mem_en` is high |

## Verification
The assertions check on every cycle that:
- `done` never lasts two cycles;
- the pointer has advanced by one whenever `done` is high;
- a held request keeps its kind and data until granted;
- the read latch moves only with `done`;
- a memory access happens only while busy;
- a blanked display grants at once;
- a quarter-rate slot is never followed by another.

Only the bench scenarios show:
- which byte lands where;
- that the prefetch returns the loaded address;
- the latency bounds of each mode;
- that requests made while busy, or together with a load, truly vanish;
- that the pointer wraps at the top of memory.

// File: rtl/cpu_slot_port_pkg.sv
// Package: shared types for the slot-gated processor byte port.
// Assumes: two-bit mode code as seen on the top-level port.
package cpu_slot_port_pkg;

    typedef enum logic [1:0] {
        SCHED_QUARTER = 2'd0,   // one spare slot in four
        SCHED_EIGHTH  = 2'd1,   // one spare slot in eight
        SCHED_BLANK   = 2'd2,   // display blanked, every slot spare
        SCHED_RSVD    = 2'd3    // treated like SCHED_EIGHTH
    } sched_mode_t;

endpackage

// File: rtl/cps_slot_sched.sv
// Module: cps_slot_sched
// Produces the spare-slot indication from a free-running slot counter
// and the selected display mode. Assumes the counter phase is tied to
// reset, so the display fetch engine shares the same phase.
module cps_slot_sched
    import cpu_slot_port_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  sched_mode_t mode,
    output logic        slot_free
);
    localparam int DENSE_W = CNT_W - 1;

    logic [CNT_W-1:0] slot_cnt;

    // Free-running slot counter, phase fixed by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_cnt <= '0;
        else        slot_cnt <= slot_cnt + 1'b1;
    end

    // Decode the spare slot for the active schedule.
    always_comb begin
        unique case (mode)
            SCHED_QUARTER: slot_free = &slot_cnt[DENSE_W-1:0];
            SCHED_BLANK:   slot_free = 1'b1;
            default:       slot_free = &slot_cnt;
        endcase
    end

    // R6
    quarter_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_free && mode == SCHED_QUARTER) |=> (mode != SCHED_QUARTER || !slot_free));

endmodule

// File: rtl/cps_addr_ptr.sv
// Module: cps_addr_ptr
// Byte address pointer: loads a start address and steps by one after
// every completed access, wrapping at the top of the address space.
// Assumes load and step are never requested in the same cycle.
module cps_addr_ptr #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    // Pointer register: load wins, otherwise step with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + 1'b1;
    end

    // R8
    load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/cps_req_hold.sv
// Module: cps_req_hold
// One-entry request holder with completion flag and read-data latch.
// Accepts a processor request or a prefetch, keeps it until a grant,
// then pulses done and latches read data. Assumes the caller accepts
// only while the holder is empty.
module cps_req_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_req,
    input  logic              accept_pref,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              grant,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pending,
    output logic              hold_we,
    output logic [DATA_W-1:0] hold_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_q
);
    // Pending flag and held request contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            hold_we    <= 1'b0;
            hold_wdata <= '0;
        end else if (accept_req) begin
            pending    <= 1'b1;
            hold_we    <= req_write;
            hold_wdata <= req_wdata;
        end else if (accept_pref) begin
            pending    <= 1'b1;
            hold_we    <= 1'b0;
        end else if (grant) begin
            pending    <= 1'b0;
        end
    end

    // Completion pulse, one cycle after the granted access.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= grant;
    end

    // Read-data latch, updated only by a granted read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_q <= '0;
        else if (grant && !hold_we) rd_q <= mem_rdata;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !grant) |=> (pending && $stable(hold_we) && $stable(hold_wdata)));

    // R10
    rd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_q));

endmodule

// File: rtl/cpu_slot_port.sv
// Module: cpu_slot_port (top)
// Processor access port into controller-owned display memory. Byte
// requests go through a pointer and a one-entry holder and are served
// only in spare display slots. Assumes the memory returns read data
// combinationally in the cycle mem_en is high.
module cpu_slot_port
    import cpu_slot_port_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              addr_load,
    input  logic              addr_rd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    sched_mode_t       mode_e;
    logic              slot_free;
    logic              pending;
    logic              hold_we;
    logic [DATA_W-1:0] hold_wdata;
    logic              take_load;
    logic              take_pref;
    logic              take_req;
    logic              grant;

    // Admission: loads beat requests, nothing is taken while busy.
    always_comb begin
        mode_e    = sched_mode_t'(mode);
        take_load = addr_load && !pending;
        take_pref = take_load && addr_rd;
        take_req  = req_valid && !addr_load && !pending;
        grant     = pending && slot_free;
    end

    cps_slot_sched #(.CNT_W(CNT_W)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .slot_free (slot_free)
    );

    cps_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_load),
        .load_val (addr_in),
        .step     (grant),
        .ptr      (cur_addr)
    );

    cps_req_hold #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_req  (take_req),
        .accept_pref (take_pref),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .grant       (grant),
        .mem_rdata   (mem_rdata),
        .pending     (pending),
        .hold_we     (hold_we),
        .hold_wdata  (hold_wdata),
        .done        (done),
        .rd_q        (rd_data)
    );

    // Drive the memory side from the granted request.
    always_comb begin
        busy      = pending;
        mem_en    = grant;
        mem_we    = grant && hold_we;
        mem_addr  = cur_addr;
        mem_wdata = hold_wdata;
    end

    // R4
    step_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_addr == $past(cur_addr) + 1'b1));

    // R7
    access_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R6
    blank_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == 2'd2) |-> mem_en);

    // R7
    idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/cpu_slot_port_tb.sv
module cpu_slot_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        addr_load = 1'b0, addr_rd = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [13:0] addr_in = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, mem_en, mem_we;
    logic [7:0]  rd_data, mem_wdata, mem_rdata;
    logic [13:0] cur_addr, mem_addr;

    int errors = 0, checks = 0, slot_viol = 0, n_access = 0, n_wr = 0;
    logic [2:0] bcnt = '0;
    logic [7:0] mem [int];

    always #5 clk = ~clk;

    cpu_slot_port u_dut (.*);

    function automatic logic [7:0] peek(input logic [13:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ {2'b00, a[13:8]};
    endfunction

    function automatic bit spare(input logic [2:0] c, input logic [1:0] m);
        case (m)
            2'd0:    return c[1:0] == 2'b11;
            2'd2:    return 1'b1;
            default: return c == 3'b111;
        endcase
    endfunction

    // memory model and R6 slot monitor
    always @(posedge clk) begin
        if (!rst_n) bcnt = '0;
        else begin
            if (mem_en) begin
                n_access++;
                if (!spare(bcnt, mode)) slot_viol++;
                if (mem_we) begin mem[int'(mem_addr)] = mem_wdata; n_wr++; end
            end
            bcnt = bcnt + 1'b1;
        end
    end
    always @(negedge clk) mem_rdata <= peek(mem_addr);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [13:0] a, input logic rd);
        @(negedge clk); addr_load = 1; addr_rd = rd; addr_in = a;
        @(negedge clk); addr_load = 0; addr_rd = 0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
    endtask

    task automatic post(input logic wr, input logic [7:0] d, output int lat, output logic b);
        @(negedge clk); req_valid = 1; req_write = wr; req_wdata = d;
        @(negedge clk); req_valid = 0; b = busy;
        wait_done(lat);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 mem_en", mem_en, 0);
        chk("R1 rd_data", rd_data, 0); chk("R1 cur_addr", cur_addr, 0);
    endtask

    task automatic t_load_plain();
        int a0 = n_access;
        load(14'h0123, 0);
        repeat (10) @(negedge clk);
        chk("R2 cur_addr", cur_addr, 14'h0123);
        chk("R2 no access", n_access - a0, 0);
        chk("R2 idle", busy, 0);
    endtask

    task automatic t_write_quarter();
        int lat; logic b;
        mode = 2'd0;
        post(1, 8'hA5, lat, b);
        chk("R7 busy after accept", b, 1);
        chk("R6 mode0 latency<=5", int'(lat <= 5), 1);
        chk("R4 byte stored", peek(14'h0123), 8'hA5);
        chk("R4 pointer step", cur_addr, 14'h0124);
        chk("R7 busy low at done", busy, 0);
        @(negedge clk); chk("R7 done one cycle", done, 0);
    endtask

    task automatic t_write_run_eighth();
        int lat; logic b;
        mode = 2'd1;
        for (int i = 0; i < 3; i++) begin
            post(1, 8'h30 + 8'(i), lat, b);
            chk("R6 mode1 latency<=9", int'(lat <= 9), 1);
        end
        chk("R4 run byte0", peek(14'h0124), 8'h30);
        chk("R4 run byte2", peek(14'h0126), 8'h32);
        chk("R4 run pointer", cur_addr, 14'h0127);
    endtask

    task automatic t_prefetch_and_read();
        int lat; logic b;
        mode = 2'd3;
        load(14'h0123, 1);
        wait_done(lat);
        chk("R3 prefetch byte", rd_data, 8'hA5);
        chk("R3 pointer", cur_addr, 14'h0124);
        mode = 2'd2;
        post(0, 8'h00, lat, b);
        chk("R5 read byte", rd_data, 8'h30);
        chk("R6 mode2 latency==2", lat, 2);
        chk("R5 pointer", cur_addr, 14'h0125);
        post(1, 8'h77, lat, b);
        chk("R10 write keeps rd_data", rd_data, 8'h30);
        repeat (3) @(negedge clk);
        chk("R10 still held", rd_data, 8'h30);
    endtask

    task automatic t_busy_ignore();
        int lat; int w0;
        mode = 2'd1;
        load(14'h0200, 0);
        w0 = n_wr;
        @(negedge clk); req_valid = 1; req_write = 1; req_wdata = 8'h11;
        @(negedge clk); req_wdata = 8'h22; addr_load = 1; addr_in = 14'h0300;
        @(negedge clk); req_valid = 0; addr_load = 0;
        wait_done(lat);
        repeat (20) @(negedge clk);
        chk("R8 first byte", peek(14'h0200), 8'h11);
        chk("R8 single write", n_wr - w0, 1);
        chk("R8 load ignored", cur_addr, 14'h0201);
    endtask

    task automatic t_wrap();
        int lat; logic b;
        mode = 2'd2;
        load(14'h3FFF, 0);
        post(1, 8'h5C, lat, b);
        chk("R9 top byte", peek(14'h3FFF), 8'h5C);
        chk("R9 wrap", cur_addr, 14'h0000);
    endtask

    task automatic t_collide();
        int a0 = n_access;
        mode = 2'd2;
        @(negedge clk); addr_load = 1; addr_in = 14'h0AAA; req_valid = 1; req_write = 1; req_wdata = 8'hEE;
        @(negedge clk); addr_load = 0; req_valid = 0;
        repeat (8) @(negedge clk);
        chk("R11 load taken", cur_addr, 14'h0AAA);
        chk("R11 request dropped", n_access - a0, 0);
        chk("R11 byte untouched", peek(14'h0AAA), 8'hAA ^ 8'h0A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load_plain();
        t_write_quarter();
        t_write_run_eighth();
        t_prefetch_and_read();
        t_busy_ignore();
        t_wrap();
        t_collide();
        chk("R6 no access outside spare slots", slot_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule